// File: doc/BRIEF.md
# Receiver Error Mask and Reporting

This block sits beside a digital audio interface receiver. The receiver raises one-cycle pulses on seven error lines. A 7-bit enable register decides which of those errors the block acknowledges. A set enable bit lets its error latch into a sticky status register, drive the error pin, raise the interrupt, and, for the five non-CRC error types, ask the audio path to treat the current sample. A clear enable bit hides its error completely.

Software writes the enable register and reads the status register. A status read returns the latched bits and clears them. Sample treatment uses a pending-period counter: every corrupting error adds one sample period, and each `sample_tick` retires one. While the count is above zero, the block asks for either a repeat of the last sample or a zeroed sample, as `hold_mode` selects.

Top module: `rxerr_gate`

## Requirements
- R1: After reset the enable register reads 0x00 (all errors hidden). The status register reads 0x00. `err_pin`, `err_irq`, `repeat_req` and `zero_req` are all low.
- R2: A write on `mask_wr_en` stores `mask_wr_data` (7 bits), and `mask_rd_data` shows it from the next cycle. `mask_rd_data[7]` always reads 0.
- R3: An error pulse whose enable bit is 0 changes no status bit. It does not raise `err_pin` or `err_irq`, and it asserts neither sample request.
- R4: An error pulse whose enable bit is 1 sets the status bit at the same position from the next cycle on, and `err_pin` is high from that cycle. The positions of both the enable bits and the status bits are: 0 parity, 1 biphase, 2 confidence, 3 validity, 4 unlock, 5 C-data CRC, 6 Q-data CRC.
- R5: `stat_rd_data` shows the latched bits, and a cycle with `stat_rd_en` high clears them at the next edge. If an enabled pulse arrives in the same cycle as the read, its bit stays set.
- R6: `err_pin` is the OR of the status bits. `err_irq` is high for exactly one cycle, the first cycle in which `err_pin` is high after being low. More errors that arrive while `err_pin` is already high do not raise `err_irq`.
- R7: Enabled errors in bits 5 and 6 (the CRC errors) never assert `repeat_req` or `zero_req`.
- R8: An enabled error in bits 0 to 4 asserts a sample request from the next cycle. With `hold_mode`=0 the request is `repeat_req`; with `hold_mode`=1 it is `zero_req`. The two are never high together.
- R9: Each enabled corrupting error adds one pending sample period, counting every bit in a cycle. Each `sample_tick` removes one. The request stays high while the count is above zero. The count saturates at 2^CNT_W-1 (15 by default).
- R10: Clearing an enable bit does not clear a status bit that is already set. That bit stays set until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_pulse_i | input | 7 | One-cycle error pulses from the receiver, bit order as in R4 |
| mask_wr_en | input | 1 | Enable register write strobe |
| mask_wr_data | input | 7 | Enable register write value |
| mask_rd_data | output | 8 | Enable register readback, bit 7 zero |
| stat_rd_en | input | 1 | Status read strobe, clears on read |
| stat_rd_data | output | 8 | Latched error status, bit 7 zero |
| hold_mode | input | 1 | 0 repeat last sample, 1 zero the sample |
| sample_tick | input | 1 | One pulse per audio sample period |
| err_pin | output | 1 | OR of the latched status bits |
| err_irq | output | 1 | One-cycle pulse on a rise of `err_pin` |
| repeat_req | output | 1 | Request to repeat the last sample |
| zero_req | output | 1 | Request to output a zero sample |

## Verification
Every result comes from a register one clock edge after its cause:
- A pulse or write applied in a cycle shows in the status register, `err_pin`, `err_irq`, the sample requests and `mask_rd_data` after the next rising edge.
- A read clears at that same edge.
- `stat_rd_data` is a direct view of the status register, so a read returns the value from before that edge.

The bench changes inputs 1 ns after a rising edge. It samples outputs 1 ns after the following edge. Counts of sample periods are checked tick by tick around the expected boundary.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NUM_ERR = 7;
  localparam int REG_W   = 8;

  localparam int E_PAR    = 0;
  localparam int E_BIP    = 1;
  localparam int E_CONF   = 2;
  localparam int E_V      = 3;
  localparam int E_UNLOCK = 4;
  localparam int E_CCRC   = 5;
  localparam int E_QCRC   = 6;

  // errors allowed to spoil the audio sample: everything except the two CRC types
  localparam logic [NUM_ERR-1:0] CORRUPT_SEL =
    ~((NUM_ERR'(1) << E_CCRC) | (NUM_ERR'(1) << E_QCRC));

  typedef enum logic {HOLD_REPEAT = 1'b0, HOLD_ZERO = 1'b1} hold_e;
endpackage

// File: rtl/rxerr_mask_reg.sv
module rxerr_mask_reg
  import rxerr_pkg::*;
#(
  parameter int N = NUM_ERR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/rxerr_latch.sv
module rxerr_latch #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         rd_clr,
  output logic [N-1:0] stat_q,
  output logic         pin,
  output logic         irq
);
  logic pin_q;

  // one sticky cell per error; a new hit beats a clearing read
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q[g] <= 1'b0;
      else if (hit[g]) stat_q[g] <= 1'b1;
      else if (rd_clr) stat_q[g] <= 1'b0;
    end
  end

  assign pin = |stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign irq = pin & ~pin_q;
endmodule

// File: rtl/rxerr_hold.sv
module rxerr_hold
  import rxerr_pkg::*;
#(
  parameter int N     = NUM_ERR,
  parameter int CNT_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] corrupt,
  input  logic         tick,
  input  logic         mode,
  output logic         repeat_req,
  output logic         zero_req
);
  localparam int NW    = $clog2(N + 1);
  localparam int SUM_W = CNT_W + NW + 1;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [NW-1:0]    n_new;
  logic             dec;
  logic [SUM_W-1:0] sum;
  logic             active;

  always_comb begin
    n_new = '0;
    for (int i = 0; i < N; i++) n_new = n_new + NW'(corrupt[i]);
  end

  assign dec = tick && (cnt_q != '0);
  assign sum = SUM_W'(cnt_q) - SUM_W'(dec) + SUM_W'(n_new);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (sum > SUM_W'(MAXV))    cnt_q <= MAXV;
    else                            cnt_q <= sum[CNT_W-1:0];
  end

  assign active     = (cnt_q != '0);
  assign repeat_req = active && (hold_e'(mode) == HOLD_REPEAT);
  assign zero_req   = active && (hold_e'(mode) == HOLD_ZERO);
endmodule

// File: rtl/rxerr_gate.sv
module rxerr_gate
  import rxerr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_pulse_i,
  input  logic               mask_wr_en,
  input  logic [NUM_ERR-1:0] mask_wr_data,
  output logic [REG_W-1:0]   mask_rd_data,
  input  logic               stat_rd_en,
  output logic [REG_W-1:0]   stat_rd_data,
  input  logic               hold_mode,
  input  logic               sample_tick,
  output logic               err_pin,
  output logic               err_irq,
  output logic               repeat_req,
  output logic               zero_req
);
  logic [NUM_ERR-1:0] mask_q;
  logic [NUM_ERR-1:0] hits;
  logic [NUM_ERR-1:0] corrupt;
  logic [NUM_ERR-1:0] stat_q;

  rxerr_mask_reg #(.N(NUM_ERR)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en),
    .wr_data(mask_wr_data), .mask_q(mask_q)
  );

  assign hits    = err_pulse_i & mask_q;
  assign corrupt = hits & CORRUPT_SEL;

  rxerr_latch #(.N(NUM_ERR)) u_latch (
    .clk(clk), .rst_n(rst_n), .hit(hits), .rd_clr(stat_rd_en),
    .stat_q(stat_q), .pin(err_pin), .irq(err_irq)
  );

  rxerr_hold #(.N(NUM_ERR), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .corrupt(corrupt), .tick(sample_tick),
    .mode(hold_mode), .repeat_req(repeat_req), .zero_req(zero_req)
  );

  assign mask_rd_data = {{(REG_W-NUM_ERR){1'b0}}, mask_q};
  assign stat_rd_data = {{(REG_W-NUM_ERR){1'b0}}, stat_q};
endmodule

// File: rtl/rxerr_gate_chk.sv
module rxerr_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] err_pulse_i,
  input logic [7:0] mask_rd_data,
  input logic       stat_rd_en,
  input logic [7:0] stat_rd_data,
  input logic       err_pin,
  input logic       err_irq,
  input logic       repeat_req,
  input logic       zero_req
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd_data[7] == 1'b0);

  assert_enabled_sets_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse_i & mask_rd_data[6:0]) != 7'd0) |=> err_pin);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_en && ((err_pulse_i & mask_rd_data[6:0]) == 7'd0)) |=> (stat_rd_data == 8'd0));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);

  assert_irq_needs_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_pin);

  assert_crc_no_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_req && !zero_req && ((err_pulse_i[4:0] & mask_rd_data[4:0]) == 5'd0))
      |=> (!repeat_req && !zero_req));

  assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({repeat_req, zero_req}) <= 1);
endmodule

bind rxerr_gate rxerr_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse_i),
  .mask_rd_data(mask_rd_data), .stat_rd_en(stat_rd_en),
  .stat_rd_data(stat_rd_data), .err_pin(err_pin), .err_irq(err_irq),
  .repeat_req(repeat_req), .zero_req(zero_req)
);

// File: tb/rxerr_gate_test.sv
`timescale 1ns/1ps
module rxerr_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] err_pulse_i = '0;
  logic       mask_wr_en = 1'b0;
  logic [6:0] mask_wr_data = '0;
  logic [7:0] mask_rd_data;
  logic       stat_rd_en = 1'b0;
  logic [7:0] stat_rd_data;
  logic       hold_mode = 1'b0;
  logic       sample_tick = 1'b0;
  logic       err_pin, err_irq, repeat_req, zero_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rxerr_gate uut (
    .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse_i),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_rd_data(mask_rd_data), .stat_rd_en(stat_rd_en),
    .stat_rd_data(stat_rd_data), .hold_mode(hold_mode),
    .sample_tick(sample_tick), .err_pin(err_pin), .err_irq(err_irq),
    .repeat_req(repeat_req), .zero_req(zero_req)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_mask(logic [6:0] v);
    mask_wr_en = 1'b1; mask_wr_data = v; step(); mask_wr_en = 1'b0;
  endtask

  task automatic pulse(logic [6:0] v);
    err_pulse_i = v; step(); err_pulse_i = '0;
  endtask

  task automatic tick();
    sample_tick = 1'b1; step(); sample_tick = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < 40 && (repeat_req || zero_req); i++) tick();
    stat_rd_en = 1'b1; step(); stat_rd_en = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1", "mask", mask_rd_data, 8'h00);
    chk("R1", "stat", stat_rd_data, 8'h00);
    chk("R1", "pin/irq/req", {err_pin, err_irq, repeat_req, zero_req}, 4'b0000);
  endtask

  task automatic t_mask_rw();
    wr_mask(7'h7F);
    chk("R2", "readback all ones, bit7 zero", mask_rd_data, 8'h7F);
    wr_mask(7'h2A);
    chk("R2", "readback pattern", mask_rd_data, 8'h2A);
    wr_mask(7'h00);
  endtask

  task automatic t_masked();
    pulse(7'h7F);
    chk("R3", "stat unchanged", stat_rd_data, 8'h00);
    chk("R3", "pin/irq/req", {err_pin, err_irq, repeat_req, zero_req}, 4'b0000);
    step();
    chk("R3", "stat later", stat_rd_data, 8'h00);
  endtask

  task automatic t_record();
    wr_mask(7'h7F); hold_mode = 1'b0;
    pulse(7'h08);
    chk("R4", "validity bit", stat_rd_data, 8'h08);
    chk("R4", "pin", err_pin, 1'b1);
    chk("R6", "irq on rise", err_irq, 1'b1);
    step();
    chk("R6", "irq one cycle", err_irq, 1'b0);
    pulse(7'h01);
    chk("R4", "parity bit added", stat_rd_data, 8'h09);
    chk("R6", "no irq while pin high", err_irq, 1'b0);
    chk("R5", "read value", stat_rd_data, 8'h09);
    stat_rd_en = 1'b1; step(); stat_rd_en = 1'b0;
    chk("R5", "cleared after read", stat_rd_data, 8'h00);
    chk("R6", "pin low after read", err_pin, 1'b0);
    flush();
  endtask

  task automatic t_collision();
    pulse(7'h04);
    err_pulse_i = 7'h02; stat_rd_en = 1'b1; step();
    err_pulse_i = '0; stat_rd_en = 1'b0;
    chk("R5", "pulse during read survives", stat_rd_data, 8'h02);
    flush();
  endtask

  task automatic t_crc();
    wr_mask(7'h60);
    pulse(7'h60);
    chk("R7", "crc bits latched", stat_rd_data, 8'h60);
    chk("R7", "no request", {repeat_req, zero_req}, 2'b00);
    wr_mask(7'h7F);
    pulse(7'h20);
    chk("R7", "crc no request full mask", {repeat_req, zero_req}, 2'b00);
    flush();
  endtask

  task automatic t_hold_modes();
    hold_mode = 1'b0;
    pulse(7'h10);
    chk("R8", "repeat mode", {repeat_req, zero_req}, 2'b10);
    tick();
    chk("R9", "one period then off", {repeat_req, zero_req}, 2'b00);
    hold_mode = 1'b1;
    pulse(7'h04);
    chk("R8", "zero mode", {repeat_req, zero_req}, 2'b01);
    tick();
    chk("R9", "zero mode off", {repeat_req, zero_req}, 2'b00);
    hold_mode = 1'b0;
    flush();
  endtask

  task automatic t_count();
    pulse(7'h07);
    tick(); tick();
    chk("R9", "three errors, two ticks", repeat_req, 1'b1);
    tick();
    chk("R9", "three errors, three ticks", repeat_req, 1'b0);
    pulse(7'h01);
    err_pulse_i = 7'h02; sample_tick = 1'b1; step();
    err_pulse_i = '0; sample_tick = 1'b0;
    chk("R9", "tick with new error keeps request", repeat_req, 1'b1);
    tick();
    chk("R9", "then retires", repeat_req, 1'b0);
    for (int i = 0; i < 4; i++) pulse(7'h1F);
    for (int i = 0; i < 14; i++) tick();
    chk("R9", "saturated, 14 ticks", repeat_req, 1'b1);
    tick();
    chk("R9", "saturated, 15 ticks", repeat_req, 1'b0);
    flush();
  endtask

  task automatic t_mask_clear();
    wr_mask(7'h7F);
    pulse(7'h10);
    wr_mask(7'h00);
    chk("R10", "bit kept after disable", stat_rd_data, 8'h10);
    chk("R10", "pin kept", err_pin, 1'b1);
    stat_rd_en = 1'b1; step(); stat_rd_en = 1'b0;
    chk("R10", "read clears", stat_rd_data, 8'h00);
    flush();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mask_rw();
    t_masked();
    t_record();
    t_collision();
    t_crc();
    t_hold_modes();
    t_count();
    t_mask_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule